// File: doc/BRIEF.md
# CCD Electronic Shutter Timing Controller

This block produces the digital frame timing for a progressive-scan interline CCD. It divides the pixel clock into four sub-phases per pixel. It counts pixel positions within a line and lines within a frame. From these counts it decodes the timing outputs:

- the horizontal readout enables,
- the per-pixel output-node reset strobe,
- the reference-level sample strobe and the data-level sample strobe,
- the vertical transfer pulse that moves photodiode charge into the vertical register,
- the substrate shutter pulse that empties the photodiodes.

Exposure is programmed in whole lines. The shutter pulse always sits inside the horizontal retrace of one line, centred with guard clocks on both sides. Picking an earlier or later line lengthens or shortens the integration time, and the frame period stays the same. The exposure value is captured once per frame, when the frame begins, so a register write in the middle of a frame cannot disturb the exposure in progress.

With two output channels, the horizontal register is split and both halves shift at the same time. Each channel therefore handles half the pixel positions, and the line time halves. The block drives logic levels only; level shifting and high-voltage pulse drivers sit outside it.

Top module: `ccd_shutter_tmg`

## Requirements
- R1: While `rst` is high, and in the one cycle after it is released, every output is low. `frame_start` rises in the second cycle after release.
- R2: `frame_start` is high for exactly one cycle: sub-phase 0 of pixel 0 of line 0. Frames repeat every 4 × (PIX_PER_LINE/NUM_CH) × LINES cycles, whatever the exposure value.
- R3: `line_valid` is high for the whole of lines 0 to ACT_LINES-1. Every bit of `hread_en` is high during pixels 0 to ACT_PIX/NUM_CH-1 of those lines, and low at all other times.
- R4: While reading, the strobes follow the sub-phase of each pixel: sub-phase 0 gives `rst_strb`, 1 gives `ref_smp`, 2 gives `dat_smp`, and 3 gives none. No strobe is high outside readout.
- R5: `vxfer` is high for VX_CLKS cycles in the retrace of the last line. It starts at retrace clock (RET_CLKS-VX_CLKS)/2, where RET_CLKS = 4 × (pixels per channel − active pixels per channel).
- R6: `shutter` is high only inside a retrace interval, for SHUT_CLKS cycles starting at retrace clock (RET_CLKS-SHUT_CLKS)/2. It is never high together with `hread_en` or `vxfer`.
- R7: For a latched exposure E in 1..LINES-1, the shutter pulse sits in the retrace of line LINES-1-E, once per frame.
- R8: An exposure of 0 behaves as an exposure of 1.
- R9: An exposure of LINES or more produces no shutter pulse, and the frame integrates for the full period.
- R10: The exposure is captured on the edge that starts a frame, and on the first edge after reset release. A change during a frame affects only the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel sub-phase clock (four per pixel) |
| rst | input | 1 | Synchronous reset, active high |
| exp_lines | input | EXP_W | Exposure in lines before frame end |
| frame_start | output | 1 | One-cycle pulse at the first cycle of a frame |
| line_valid | output | 1 | High through each active line |
| hread_en | output | NUM_CH | Horizontal readout enable, one per channel |
| rst_strb | output | 1 | Output-node reset strobe |
| ref_smp | output | 1 | Reference-level sample strobe |
| dat_smp | output | 1 | Data-level sample strobe |
| vxfer | output | 1 | Photodiode-to-vertical-register transfer pulse |
| shutter | output | 1 | Substrate shutter pulse |

## Verification
Every output is a decode of registered counters, so each result is due in the same cycle as the counter state it belongs to. The exposure value takes effect one frame boundary after the edge that captures it. The bench model steps its own cycle index on each rising edge, captures the exposure at the same frame boundary, and queues the expected output set for that cycle. A monitor pops that entry on the following falling edge, compares each field against its requirement, and so never samples on the edge where the outputs change.

// File: rtl/ccd_tmg_pkg.sv
package ccd_tmg_pkg;

  typedef enum logic [1:0] {
    PH_RST  = 2'd0,
    PH_REF  = 2'd1,
    PH_DAT  = 2'd2,
    PH_IDLE = 2'd3
  } subph_e;

  // first clock of a pulse of 'width' centred in a span of 'span' clocks
  function automatic int centre_start(int span, int width);
    return (span - width) / 2;
  endfunction

  function automatic logic in_win(int idx, int span, int width);
    int s;
    s = centre_start(span, width);
    return (idx >= s) && (idx < s + width);
  endfunction

  // line whose retrace carries the shutter pulse, -1 when none
  function automatic int shutter_line(int expo, int lpf);
    int e;
    e = (expo == 0) ? 1 : expo;
    if (e >= lpf) return -1;
    return lpf - 1 - e;
  endfunction

endpackage

// File: rtl/ccd_pix_phase.sv
module ccd_pix_phase
  import ccd_tmg_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  output subph_e ph,
  output logic   run,
  output logic   pix_end
);
  logic [1:0] ph_q;
  logic       run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q  <= 2'd0;
      run_q <= 1'b0;
    end else if (!run_q) begin
      run_q <= 1'b1;
    end else begin
      ph_q <= ph_q + 2'd1;
    end
  end

  assign ph      = subph_e'(ph_q);
  assign run     = run_q;
  assign pix_end = run_q && (ph_q == 2'd3);
endmodule

// File: rtl/ccd_raster_cnt.sv
module ccd_raster_cnt
  import ccd_tmg_pkg::*;
#(
  parameter int PCH    = 1024,
  parameter int ACT_CH = 1008,
  parameter int LPF    = 1024,
  parameter int ACT_L  = 1018,
  parameter int PIX_W  = $clog2(PCH),
  parameter int LINE_W = $clog2(LPF),
  parameter int RI_W   = $clog2(4 * (PCH - ACT_CH) + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              pix_end,
  input  subph_e            ph,
  output logic [LINE_W-1:0] line,
  output logic              act_pix,
  output logic              act_line,
  output logic              in_retrace,
  output logic [RI_W-1:0]   ret_idx,
  output logic              top_left,
  output logic              frame_wrap
);
  logic [PIX_W-1:0]  pix_q;
  logic [LINE_W-1:0] line_q;
  logic              last_pix, last_line;
  int                ri;

  assign last_pix  = (pix_q == PIX_W'(PCH - 1));
  assign last_line = (line_q == LINE_W'(LPF - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      pix_q  <= '0;
      line_q <= '0;
    end else if (pix_end) begin
      if (last_pix) begin
        pix_q  <= '0;
        line_q <= last_line ? '0 : line_q + LINE_W'(1);
      end else begin
        pix_q <= pix_q + PIX_W'(1);
      end
    end
  end

  always_comb begin
    ri      = (int'(pix_q) - ACT_CH) * 4 + int'(ph);
    ret_idx = in_retrace ? RI_W'(ri) : '0;
  end

  assign line       = line_q;
  assign act_pix    = run && (int'(pix_q) < ACT_CH);
  assign act_line   = run && (int'(line_q) < ACT_L);
  assign in_retrace = run && (int'(pix_q) >= ACT_CH);
  assign top_left   = run && (pix_q == '0) && (line_q == '0) && (ph == PH_RST);
  assign frame_wrap = pix_end && last_pix && last_line;
endmodule

// File: rtl/ccd_shutter_sched.sv
module ccd_shutter_sched
  import ccd_tmg_pkg::*;
#(
  parameter int LPF     = 1024,
  parameter int EXP_W   = 11,
  parameter int RET_CLK = 64,
  parameter int SHUT_W  = 8,
  parameter int VX_W    = 16,
  parameter int LINE_W  = $clog2(LPF),
  parameter int RI_W    = $clog2(RET_CLK + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              frame_wrap,
  input  logic [EXP_W-1:0]  exp_lines,
  input  logic [LINE_W-1:0] line,
  input  logic              in_retrace,
  input  logic [RI_W-1:0]   ret_idx,
  output logic              latch_evt,
  output logic [EXP_W-1:0]  exp_q,
  output logic              shutter,
  output logic              vxfer
);
  int   sl;
  logic armed, shut_win, vx_win;

  // capture at the edge that begins a frame (first frame included)
  assign latch_evt = !run || frame_wrap;

  always_ff @(posedge clk) begin
    if (rst || latch_evt) exp_q <= exp_lines;
  end

  always_comb begin
    sl       = shutter_line(int'(exp_q), LPF);
    armed    = (sl >= 0);
    shut_win = in_win(int'(ret_idx), RET_CLK, SHUT_W);
    vx_win   = in_win(int'(ret_idx), RET_CLK, VX_W);
  end

  assign shutter = in_retrace && armed && (int'(line) == sl) && shut_win;
  assign vxfer   = in_retrace && (line == LINE_W'(LPF - 1)) && vx_win;
endmodule

// File: rtl/ccd_shutter_tmg.sv
module ccd_shutter_tmg
  import ccd_tmg_pkg::*;
#(
  parameter int PIX_PER_LINE = 1024,
  parameter int ACT_PIX      = 1008,
  parameter int LINES        = 1024,
  parameter int ACT_LINES    = 1018,
  parameter int NUM_CH       = 1,
  parameter int SHUT_CLKS    = 8,
  parameter int VX_CLKS      = 16,
  parameter int EXP_W        = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [EXP_W-1:0]  exp_lines,
  output logic              frame_start,
  output logic              line_valid,
  output logic [NUM_CH-1:0] hread_en,
  output logic              rst_strb,
  output logic              ref_smp,
  output logic              dat_smp,
  output logic              vxfer,
  output logic              shutter
);
  localparam int PCH     = PIX_PER_LINE / NUM_CH;
  localparam int ACT_CH  = ACT_PIX / NUM_CH;
  localparam int RET_CLK = 4 * (PCH - ACT_CH);
  localparam int PIX_W   = $clog2(PCH);
  localparam int LINE_W  = $clog2(LINES);
  localparam int RI_W    = $clog2(RET_CLK + 1);

  subph_e            ph;
  logic              run, pix_end;
  logic [LINE_W-1:0] line;
  logic              act_pix, act_line, in_retrace, top_left, frame_wrap;
  logic [RI_W-1:0]   ret_idx;
  logic              latch_evt;
  logic [EXP_W-1:0]  exp_q;
  logic              rd_act;

  ccd_pix_phase u_ph (
    .clk(clk), .rst(rst), .ph(ph), .run(run), .pix_end(pix_end)
  );

  ccd_raster_cnt #(
    .PCH(PCH), .ACT_CH(ACT_CH), .LPF(LINES), .ACT_L(ACT_LINES),
    .PIX_W(PIX_W), .LINE_W(LINE_W), .RI_W(RI_W)
  ) u_rast (
    .clk(clk), .rst(rst), .run(run), .pix_end(pix_end), .ph(ph),
    .line(line), .act_pix(act_pix), .act_line(act_line),
    .in_retrace(in_retrace), .ret_idx(ret_idx), .top_left(top_left),
    .frame_wrap(frame_wrap)
  );

  ccd_shutter_sched #(
    .LPF(LINES), .EXP_W(EXP_W), .RET_CLK(RET_CLK), .SHUT_W(SHUT_CLKS),
    .VX_W(VX_CLKS), .LINE_W(LINE_W), .RI_W(RI_W)
  ) u_sch (
    .clk(clk), .rst(rst), .run(run), .frame_wrap(frame_wrap),
    .exp_lines(exp_lines), .line(line), .in_retrace(in_retrace),
    .ret_idx(ret_idx), .latch_evt(latch_evt), .exp_q(exp_q),
    .shutter(shutter), .vxfer(vxfer)
  );

  assign rd_act = act_pix && act_line;

  // split register halves shift together
  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    assign hread_en[g] = rd_act;
  end

  assign frame_start = top_left;
  assign line_valid  = act_line;
  assign rst_strb    = rd_act && (ph == PH_RST);
  assign ref_smp     = rd_act && (ph == PH_REF);
  assign dat_smp     = rd_act && (ph == PH_DAT);
endmodule

// File: rtl/ccd_shutter_tmg_chk.sv
module ccd_shutter_tmg_chk #(
  parameter int EXP_W = 11
) (
  input logic             clk,
  input logic             rst,
  input logic             frame_start,
  input logic             line_valid,
  input logic             rd_act,
  input logic             in_retrace,
  input logic             rst_strb,
  input logic             ref_smp,
  input logic             dat_smp,
  input logic             vxfer,
  input logic             shutter,
  input logic             latch_evt,
  input logic [EXP_W-1:0] exp_q
);
  // R4
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rst_strb, ref_smp, dat_smp}));
  // R4
  reset_then_ref_chk: assert property (@(posedge clk) disable iff (rst)
    rst_strb |=> ref_smp);
  // R4
  ref_then_data_chk: assert property (@(posedge clk) disable iff (rst)
    ref_smp |=> dat_smp);
  // R6
  shutter_in_retrace_chk: assert property (@(posedge clk) disable iff (rst)
    shutter |-> (in_retrace && !rd_act));
  // R6
  shutter_vx_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(shutter && vxfer));
  // R2
  frame_start_single_chk: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> !frame_start);
  // R3
  read_in_line_chk: assert property (@(posedge clk) disable iff (rst)
    rd_act |-> line_valid);
  // R10
  exposure_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !latch_evt |=> $stable(exp_q));
endmodule

bind ccd_shutter_tmg ccd_shutter_tmg_chk #(.EXP_W(EXP_W)) u_chk (
  .clk(clk), .rst(rst), .frame_start(frame_start), .line_valid(line_valid),
  .rd_act(rd_act), .in_retrace(in_retrace), .rst_strb(rst_strb),
  .ref_smp(ref_smp), .dat_smp(dat_smp), .vxfer(vxfer), .shutter(shutter),
  .latch_evt(latch_evt), .exp_q(exp_q)
);

// File: tb/tb_ccd_shutter_tmg.sv
module tb_ccd_shutter_tmg;
  localparam int PPL = 24, APX = 16, NL = 8, ANL = 6, NCH = 2;
  localparam int SHW = 6, VXW = 8, EW = 5;
  localparam int CLK_PER_LINE = 4 * (PPL / NCH);
  localparam int FRAME = CLK_PER_LINE * NL;
  localparam int RD_CLKS = 4 * (APX / NCH);
  localparam int BLANK = CLK_PER_LINE - RD_CLKS;

  typedef struct packed {
    logic fs, lv, hr, rs, rf, ds, vx, sh;
  } obs_t;

  logic clk = 1'b0, rst = 1'b1;
  logic [EW-1:0] exp_lines = 5'd3;
  logic frame_start, line_valid, rst_strb, ref_smp, dat_smp, vxfer, shutter;
  logic [NCH-1:0] hread_en;

  int checks = 0, failures = 0;
  bit done = 0;
  string sh_tag = "R7";
  obs_t q[$];

  ccd_shutter_tmg #(
    .PIX_PER_LINE(PPL), .ACT_PIX(APX), .LINES(NL), .ACT_LINES(ANL),
    .NUM_CH(NCH), .SHUT_CLKS(SHW), .VX_CLKS(VXW), .EXP_W(EW)
  ) dut (
    .clk(clk), .rst(rst), .exp_lines(exp_lines), .frame_start(frame_start),
    .line_valid(line_valid), .hread_en(hread_en), .rst_strb(rst_strb),
    .ref_smp(ref_smp), .dat_smp(dat_smp), .vxfer(vxfer), .shutter(shutter)
  );

  always #10 clk = ~clk;

  // expected outputs for cycle n of a frame with captured exposure e
  function automatic obs_t predict(int n, int e);
    obs_t o;
    int ln, off, slot, tgt, eff;
    ln   = n / CLK_PER_LINE;
    off  = n % CLK_PER_LINE;
    slot = off - RD_CLKS;
    eff  = (e < 1) ? 1 : e;
    tgt  = (eff < NL) ? (NL - 1 - eff) : -100;
    o.fs = (n == 0);
    o.lv = (ln < ANL);
    o.hr = o.lv && (off < RD_CLKS);
    o.rs = o.hr && (off % 4 == 0);
    o.rf = o.hr && (off % 4 == 1);
    o.ds = o.hr && (off % 4 == 2);
    o.vx = (ln == NL - 1) && slot >= (BLANK - VXW) / 2 && slot < (BLANK - VXW) / 2 + VXW;
    o.sh = (ln == tgt) && slot >= (BLANK - SHW) / 2 && slot < (BLANK - SHW) / 2 + SHW;
    return o;
  endfunction

  // driver side: advance own model on each edge and queue the expectation
  int  mn = 0, mlat = 0;
  bit  mrun = 0;
  always @(posedge clk) begin
    if (rst) begin
      mrun = 0; mn = 0; mlat = int'(exp_lines);
      q.push_back('0);
    end else if (!mrun) begin
      mrun = 1; mn = 0; mlat = int'(exp_lines);
      q.push_back(predict(mn, mlat));
    end else begin
      if (mn == FRAME - 1) mlat = int'(exp_lines);
      mn = (mn + 1) % FRAME;
      q.push_back(predict(mn, mlat));
    end
  end

  task automatic cmp(input logic act, input logic expv, input string tag, input string nm);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", tag, nm, act, expv, $time);
    end
  endtask

  // monitor: pop and compare away from the active edge
  always @(negedge clk) begin
    if (q.size() > 0) begin
      obs_t e;
      bit idle;
      e = q.pop_front();
      idle = (e == '0) && !mrun;
      cmp(frame_start, e.fs, idle ? "R1" : "R2", "frame_start");
      cmp(line_valid, e.lv, idle ? "R1" : "R3", "line_valid");
      cmp(hread_en == {NCH{1'b1}}, e.hr, idle ? "R1" : "R3", "hread_en_all");
      cmp(|hread_en, e.hr, idle ? "R1" : "R3", "hread_en_any");
      cmp(rst_strb, e.rs, idle ? "R1" : "R4", "rst_strb");
      cmp(ref_smp, e.rf, idle ? "R1" : "R4", "ref_smp");
      cmp(dat_smp, e.ds, idle ? "R1" : "R4", "dat_smp");
      cmp(vxfer, e.vx, idle ? "R1" : "R5", "vxfer");
      cmp(shutter, e.sh, idle ? "R1" : {"R6 ", sh_tag}, "shutter");
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_exp(input int v, input string tag);
    exp_lines = EW'(v);
    sh_tag = tag;
  endtask

  initial begin
    tick(5);
    rst = 1'b0;                        // R1: idle cycle, then frame start
    tick(FRAME / 4);
    set_exp(5, "R10");                 // mid-frame write, current frame keeps 3
    tick(FRAME);
    set_exp(0, "R8");                  // 0 acts as 1
    tick(FRAME);
    set_exp(NL - 1, "R7");             // earliest line
    tick(FRAME);
    set_exp(NL, "R9");                 // no pulse
    tick(FRAME);
    set_exp(20, "R9");
    tick(FRAME);
    set_exp(1, "R7");
    tick(FRAME);
    set_exp(2, "R10");
    tick(FRAME / 3);
    rst = 1'b1;                        // R1: reset mid-frame
    tick(4);
    rst = 1'b0;
    tick(2 * FRAME);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule